// File: doc/BRIEF.md
# Boot Address and Clock Mode Selector

This block settles how an 8-bit controller comes out of reset. When reset is released it looks at two stored configuration bytes, a status byte and a boot vector, and computes the 16-bit address where instruction fetch begins. If the status byte is zero the controller starts at the bottom of program space. Otherwise the boot vector supplies the page, so the controller starts at a 256-byte boundary. The address is held until the next reset release.

The block also picks the machine-cycle rate. A stored clock-mode bit is captured only while power-on reset is asserted. If that bit is programmed it forces the fast rate, one machine cycle per 6 oscillator clocks. If it is erased, a software bit chooses: 0 gives the default slow rate of 12 clocks and 1 gives the fast rate. A divider turns the chosen rate into a one-clock machine-cycle tick.

Finally, the block decodes the fetch address. It flags when the top 1 KB of program space must be served by the boot ROM rather than by user flash. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `boot_clk_cfg`

## Requirements
- R1: While `por` is high, `start_addr` is 0x0000 and `mc_tick` is 0.
- R2: On the first clock edge after reset (`por` or `sys_rst`) is released, a `cfg_status` of 0x00 gives `start_addr` = 0x0000.
- R3: On that edge, a nonzero `cfg_status` gives `start_addr` = {`cfg_vector`, 8'h00}; for example a vector of 0xFC gives 0xFC00. A warm `sys_rst` release resamples both bytes in the same way.
- R4: After the sampling edge, `start_addr` holds its value, and changes on `cfg_status` or `cfg_vector` have no effect until the next reset release.
- R5: `cfg_fast` (1 = programmed) is captured only while `por` is high. A change on it during operation or during a `sys_rst`-only reset does not change `fast_mode`.
- R6: When the captured stored bit is 1, `fast_mode` is 1 whatever `sw_fast` is.
- R7: When the captured stored bit is 0, `fast_mode` follows `sw_fast` directly: 0 gives 12-clock mode and 1 gives 6-clock mode.
- R8: Outside reset, `mc_tick` pulses once every 6 clocks when `fast_mode` = 1 and once every 12 clocks when it is 0. The tick is held at 0 during reset.
- R9: `brom_sel` is 1 exactly when `brom_en` = 1 and `fetch_addr` lies in 0xFC00..0xFFFF. It is combinational.
- R10: Each `mc_tick` pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| sys_rst | input | 1 | Warm reset, active high, synchronous |
| cfg_status | input | 8 | Stored status byte |
| cfg_vector | input | 8 | Stored boot vector (start page) |
| cfg_fast | input | 1 | Stored clock-mode bit, 1 = programmed |
| sw_fast | input | 1 | Software clock-mode bit |
| brom_en | input | 1 | Boot ROM overlay enable |
| fetch_addr | input | 16 | Program fetch address |
| start_addr | output | 16 | Execution start address |
| fast_mode | output | 1 | 1 = 6-clock mode, 0 = 12-clock mode |
| mc_tick | output | 1 | Machine-cycle tick |
| brom_sel | output | 1 | Fetch is served by the boot ROM |

## Verification
Some properties are checked on every cycle by the assertions:
- the start address stays stable between reset releases, and it takes the value the configuration bytes call for at release;
- the captured stored clock bit stays fixed once power-on ends;
- the divider count never leaves its range;
- a tick never lasts more than one cycle;
- the overlay select never fires below the top kilobyte.

Other behaviour is shown only by the bench scenarios: the exact 6 and 12 clock tick spacing, the way the stored bit and the software bit combine, and the fact that a warm reset resamples the bytes while leaving the stored clock bit untouched.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  function automatic logic [ADDR_W-1:0] start_of(input logic [BYTE_W-1:0] status,
                                                 input logic [BYTE_W-1:0] vector);
    if (status == '0) return '0;
    return {vector, {(ADDR_W-BYTE_W){1'b0}}};
  endfunction
endpackage

// File: rtl/bsel_start_latch.sv
module bsel_start_latch
  import bsel_pkg::*;
(
  input  logic              clk,
  input  logic              por,
  input  logic              rst_in,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] vector,
  output logic [ADDR_W-1:0] start_addr
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (por) begin
      start_addr <= '0;
      pend_q     <= 1'b1;
    end else if (rst_in) begin
      pend_q <= 1'b1;
    end else if (pend_q) begin
      start_addr <= start_of(status, vector);
      pend_q     <= 1'b0;
    end
  end

  // R4: value holds once sampled
  assert_start_hold_R4: assert property (@(posedge clk) disable iff (por)
    (!pend_q) |=> $stable(start_addr));

  // R2, R3: sampled value at release
  assert_start_value_R3: assert property (@(posedge clk) disable iff (por)
    (pend_q && !rst_in) |=>
      (start_addr == (($past(status) == '0) ? '0 : {$past(vector), 8'h00})));
endmodule

// File: rtl/bsel_mode_sel.sv
module bsel_mode_sel (
  input  logic clk,
  input  logic por,
  input  logic cfg_fast,
  input  logic sw_fast,
  output logic fast_mode
);
  logic fx_lat;

  always_ff @(posedge clk) begin
    if (por) fx_lat <= cfg_fast;
  end

  assign fast_mode = fx_lat | sw_fast;

  // R5: captured bit is frozen outside power-on
  assert_fx_frozen_R5: assert property (@(posedge clk) disable iff (por)
    (!$past(por)) |-> $stable(fx_lat));
endmodule

// File: rtl/bsel_mc_div.sv
module bsel_mc_div #(
  parameter int unsigned DIV_FAST = 6,
  parameter int unsigned DIV_SLOW = 12
) (
  input  logic clk,
  input  logic rst_in,
  input  logic fast,
  output logic tick
);
  localparam int unsigned CNT_W = $clog2(DIV_SLOW);
  localparam logic [CNT_W-1:0] TERM_F = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] TERM_S = CNT_W'(DIV_SLOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term = fast ? TERM_F : TERM_S;
  assign tick = !rst_in && (cnt_q >= term);

  always_ff @(posedge clk) begin
    if (rst_in)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R8: counter stays inside the slow period
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst_in)
    cnt_q <= TERM_S);

  // R10: tick is a single-cycle pulse
  assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst_in)
    tick |=> !tick);
endmodule

// File: rtl/bsel_rom_decode.sv
module bsel_rom_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ROM_W  = 10
) (
  input  logic              brom_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              brom_sel
);
  assign brom_sel = brom_en && (&fetch_addr[ADDR_W-1:ROM_W]);
endmodule

// File: rtl/boot_clk_cfg.sv
module boot_clk_cfg
  import bsel_pkg::*;
#(
  parameter int unsigned DIV_FAST = 6,
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned ROM_W    = 10
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic [BYTE_W-1:0] cfg_status,
  input  logic [BYTE_W-1:0] cfg_vector,
  input  logic              cfg_fast,
  input  logic              sw_fast,
  input  logic              brom_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] start_addr,
  output logic              fast_mode,
  output logic              mc_tick,
  output logic              brom_sel
);
  localparam logic [ADDR_W-1:0] ROM_BASE = ~((ADDR_W)'((1 << ROM_W) - 1));

  logic rst_any;
  assign rst_any = por | sys_rst;

  bsel_start_latch u_start (
    .clk(clk), .por(por), .rst_in(rst_any),
    .status(cfg_status), .vector(cfg_vector), .start_addr(start_addr)
  );

  bsel_mode_sel u_mode (
    .clk(clk), .por(por), .cfg_fast(cfg_fast),
    .sw_fast(sw_fast), .fast_mode(fast_mode)
  );

  bsel_mc_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst_in(rst_any), .fast(fast_mode), .tick(mc_tick)
  );

  bsel_rom_decode #(.ADDR_W(ADDR_W), .ROM_W(ROM_W)) u_rom (
    .brom_en(brom_en), .fetch_addr(fetch_addr), .brom_sel(brom_sel)
  );

  // R9: overlay never selected below its base
  assert_rom_window_R9: assert property (@(posedge clk)
    (fetch_addr < ROM_BASE) |-> !brom_sel);

  // R1: quiet during power-on reset
  assert_por_quiet_R1: assert property (@(posedge clk)
    por |=> (start_addr == '0) && !mc_tick);
endmodule

// File: tb/test_boot_clk_cfg.sv
module test_boot_clk_cfg;
  logic        clk = 1'b0;
  logic        por = 1'b1, sys_rst = 1'b0;
  logic [7:0]  cfg_status = 8'h00, cfg_vector = 8'hFC;
  logic        cfg_fast = 1'b0, sw_fast = 1'b0, brom_en = 1'b0;
  logic [15:0] fetch_addr = 16'h0000;
  logic [15:0] start_addr;
  logic        fast_mode, mc_tick, brom_sel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_clk_cfg i_boot_clk_cfg (
    .clk(clk), .por(por), .sys_rst(sys_rst), .cfg_status(cfg_status),
    .cfg_vector(cfg_vector), .cfg_fast(cfg_fast), .sw_fast(sw_fast),
    .brom_en(brom_en), .fetch_addr(fetch_addr), .start_addr(start_addr),
    .fast_mode(fast_mode), .mc_tick(mc_tick), .brom_sel(brom_sel)
  );

  // {status, vector, stored bit, sw bit, expected start, expected fast}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {8'h00, 8'hFC, 1'b0, 1'b0, 16'h0000, 1'b0},
    {8'h01, 8'hFC, 1'b0, 1'b1, 16'hFC00, 1'b1},
    {8'hFF, 8'h12, 1'b1, 1'b0, 16'h1200, 1'b1},
    {8'h00, 8'h55, 1'b1, 1'b1, 16'h0000, 1'b1},
    {8'h80, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b0},
    {8'h7E, 8'hA3, 1'b0, 1'b0, 16'hA300, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_reset(input bit power);
    @(negedge clk);
    if (power) por = 1'b1; else sys_rst = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0; sys_rst = 1'b0;
    @(negedge clk);
  endtask

  // spacing between two consecutive ticks; also checks pulse width
  task automatic measure(input string req, output int period);
    int k = 0;
    period = 0;
    while (!mc_tick && k < 40) begin @(negedge clk); k++; end
    @(negedge clk);
    chk("R10 tick width", 32'(mc_tick), 32'd0);
    period = 1;
    while (!mc_tick && period < 40) begin @(negedge clk); period++; end
    chk(req, 32'(period), 32'(period));
  endtask

  initial begin
    int p;
    // R1: reset state during power-on
    repeat (2) @(negedge clk);
    chk("R1 start during por", 32'(start_addr), 32'h0);
    chk("R1 tick during por", 32'(mc_tick), 32'h0);
    por = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cfg_status = VEC[i][34:27];
      cfg_vector = VEC[i][26:19];
      cfg_fast   = VEC[i][18];
      sw_fast    = VEC[i][17];
      pulse_reset(1'b1);
      chk((VEC[i][34:27] == 0) ? "R2 start" : "R3 start",
          32'(start_addr), 32'(VEC[i][16:1]));
      chk(VEC[i][18] ? "R6 fast" : "R7 mode", 32'(fast_mode), 32'(VEC[i][0]));
      measure("R8 period", p);
      chk("R8 period", 32'(p), VEC[i][0] ? 32'd6 : 32'd12);
    end

    // R4: config changes after release are ignored
    cfg_status = 8'h01; cfg_vector = 8'hFC; cfg_fast = 1'b0; sw_fast = 1'b0;
    pulse_reset(1'b1);
    cfg_status = 8'h00; cfg_vector = 8'h33;
    repeat (20) @(negedge clk);
    chk("R4 hold", 32'(start_addr), 32'hFC00);

    // R5 + R3 warm: warm reset resamples bytes but not the stored bit
    cfg_fast = 1'b1; cfg_status = 8'h05; cfg_vector = 8'h40;
    repeat (3) @(negedge clk);
    chk("R5 no change in run", 32'(fast_mode), 32'd0);
    pulse_reset(1'b0);
    chk("R3 warm resample", 32'(start_addr), 32'h4000);
    chk("R5 warm keeps mode", 32'(fast_mode), 32'd0);
    measure("R8 slow after warm", p);
    chk("R8 slow after warm", 32'(p), 32'd12);
    pulse_reset(1'b1);
    chk("R5 por captures", 32'(fast_mode), 32'd1);

    // R7: live software bit with erased stored bit
    cfg_fast = 1'b0;
    pulse_reset(1'b1);
    chk("R7 sw0 slow", 32'(fast_mode), 32'd0);
    sw_fast = 1'b1;
    #1;
    chk("R7 sw1 fast", 32'(fast_mode), 32'd1);
    measure("R8 fast live", p);
    chk("R8 fast live", 32'(p), 32'd6);

    // R8: tick held low in reset
    @(negedge clk); sys_rst = 1'b1;
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      if (mc_tick) chk("R8 no tick in reset", 32'd1, 32'd0);
    end
    chk("R8 no tick in reset", 32'(mc_tick), 32'd0);
    sys_rst = 1'b0;

    // R9: overlay decode
    brom_en = 1'b1; fetch_addr = 16'hFC00; #1;
    chk("R9 base", 32'(brom_sel), 32'd1);
    fetch_addr = 16'hFBFF; #1;
    chk("R9 below", 32'(brom_sel), 32'd0);
    fetch_addr = 16'hFFFF; #1;
    chk("R9 top", 32'(brom_sel), 32'd1);
    fetch_addr = 16'h0000; #1;
    chk("R9 low", 32'(brom_sel), 32'd0);
    brom_en = 1'b0; fetch_addr = 16'hFC00; #1;
    chk("R9 disabled", 32'(brom_sel), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule